// File: doc/BRIEF.md
# Clock-Generator Configuration Register Slave (SMBus block access)

This block is a two-wire SMBus slave that keeps seven 8-bit configuration bytes for a clock generator. It is reached only through block transfers. No register address is ever sent. A write carries a command byte and a count byte, which are both acknowledged and then dropped. The data bytes that follow fill the registers in order, starting at byte 0. The master may send STOP after any whole byte. A read returns a count byte and then all seven registers in order.

SCL and SDA are sampled by a fast system clock through a synchronizer chain. START and STOP are detected from the synchronized lines. SDA is driven open-drain through a single pull-low enable. The register contents go to the clock-control logic on a flat bus. That bus carries the same view the master reads back: writable bits masked, fixed bits forced, and status inputs merged in.

Top module: `clkcfg_smb_slave`

## Requirements
- R1: After reset the register bytes read back as follows (index: value):
  - 0: 0x08 with bits 2:1 set from the latched frequency-select pins.
  - 1: 0x47 with bit 7 set from the select pin.
  - 2: 0x7F.
  - 3: 0xC7.
  - 4: 0x3F.
  - 5: 0x00.
  - 6: the identity byte.
- R2: The slave acknowledges address byte 0xD2 (write) and 0xD3 (read) by pulling SDA low in the ninth clock. Any other address byte is not acknowledged, and the transfer it starts changes nothing. SDA is only ever pulled low while SCL is low.
- R3: In a write, the first two bytes after the address are acknowledged, and their values have no effect on any register.
- R4: In a write, the third and later bytes after the address load register 0, 1, 2 and so on, one per byte. After a STOP that follows any whole byte, registers that were not reached keep their values.
- R5: A read returns the count byte 0x07 first, then register bytes 0 through 6 in order, MSB first.
- R6: Byte 6 is the identity byte {REV_ID, 4'b0001}, with REV_ID defaulting to 4'h2. Writes to it have no effect.
- R7: Bits 2:1 of byte 0 show the frequency-select pins as they were captured in the first cycle after reset. Bit 7 of byte 1 shows the select pin's current level. No write changes these bits.
- R8: Written data is masked per byte. The writable bits are:
  - byte 0: 0xA8
  - byte 1: 0x47
  - byte 2: 0x7F
  - byte 3: 0xFF
  - byte 4: 0x3F
  - byte 5: 0x0F
  
  All other bits that are not status bits always read 0.
- R9: When the master does not acknowledge a read byte, the slave stops transmitting and leaves SDA released until the next START.
- R10: A START or STOP seen inside a byte aborts the transfer. Bytes completed before it stay stored, and the partial byte is discarded.
- R11: A data byte beyond the seventh in one write is not acknowledged and is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SMBus clock line level |
| sda_i | input | 1 | SMBus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| fsel_pins | input | 2 | Frequency-select pins, captured once after reset |
| sel_pin | input | 1 | Select pin, reported live |
| cfg_o | output | 56 | Read-back view of bytes 0..6, byte i at bits 8i+7:8i |

## Verification
On every cycle, the assertions check the following:
- SDA is pulled low only after SCL has gone low, and it is never pulled while the protocol machine is idle.
- A register write fires only together with an acknowledge, and always targets an existing register.
- The captured frequency-select bits never change after the capture.

Only the bench's transfers can show the protocol-level behaviour:
- Byte ordering and masking, checked across a sweep of data patterns.
- That the command and count bytes are dropped.
- Partial-write retention, and the abort on a START or STOP inside a byte.
- The NACK of an extra data byte, and the release of SDA after a master NACK.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

   localparam int NREG = 7;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RECV,
      ST_ACKOUT,
      ST_SEND,
      ST_ACKIN
   } smb_st_t;

   // power-on value of the writable part of each byte
   function automatic logic [7:0] reg_default(input int idx);
      case (idx)
         0:       return 8'h08;
         1:       return 8'h47;
         2:       return 8'h7F;
         3:       return 8'hC7;
         4:       return 8'h3F;
         default: return 8'h00;
      endcase
   endfunction

   // bits a write may change in each byte
   function automatic logic [7:0] reg_wmask(input int idx);
      case (idx)
         0:       return 8'hA8;
         1:       return 8'h47;
         2:       return 8'h7F;
         3:       return 8'hFF;
         4:       return 8'h3F;
         5:       return 8'h0F;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("smb_line_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_q, sda_q;
   logic              scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= '1;
         sda_q <= '1;
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_q <= {scl_q[STAGES-2:0], scl_i};
         sda_q <= {sda_q[STAGES-2:0], sda_i};
         scl_p <= scl_q[STAGES-1];
         sda_p <= sda_q[STAGES-1];
      end
   end

   assign scl_s     = scl_q[STAGES-1];
   assign sda_s     = sda_q[STAGES-1];
   assign scl_rise  = scl_s & ~scl_p;
   assign scl_fall  = ~scl_s & scl_p;
   assign start_det = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/smb_proto.sv
module smb_proto
   import clkcfg_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h69,
   parameter int         NR       = NREG,
   localparam int        IW       = $clog2(NR),
   localparam int        CW       = $clog2(NR + 4)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_s,
   input  logic          sda_s,
   input  logic          scl_rise,
   input  logic          scl_fall,
   input  logic          start_det,
   input  logic          stop_det,
   input  logic [7:0]    rd_byte_i,
   output logic [IW-1:0] rd_sel,
   output logic          sda_oe,
   output logic          wr_en,
   output logic [IW-1:0] wr_idx,
   output logic [7:0]    wr_data
);
   smb_st_t       st;
   logic [3:0]    bitcnt;
   logic [7:0]    shreg;
   logic [CW-1:0] byte_idx;
   logic          is_rd;
   logic          acked;

   assign rd_sel = IW'(byte_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         bitcnt   <= '0;
         shreg    <= '0;
         byte_idx <= '0;
         is_rd    <= 1'b0;
         acked    <= 1'b0;
         sda_oe   <= 1'b0;
         wr_en    <= 1'b0;
         wr_idx   <= '0;
         wr_data  <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_det) begin
            st       <= ST_RECV;
            bitcnt   <= '0;
            byte_idx <= '0;
            is_rd    <= 1'b0;
            sda_oe   <= 1'b0;
         end else if (stop_det) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (st)
               ST_RECV: begin
                  if (scl_rise && bitcnt != 4'd8) begin
                     shreg  <= {shreg[6:0], sda_s};
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall && bitcnt == 4'd8) begin
                     if (byte_idx == '0) begin
                        if (shreg[7:1] == DEV_ADDR) begin
                           is_rd  <= shreg[0];
                           sda_oe <= 1'b1;
                           st     <= ST_ACKOUT;
                        end else begin
                           st <= ST_IDLE;
                        end
                     end else if (byte_idx < CW'(NR + 3)) begin
                        sda_oe <= 1'b1;
                        st     <= ST_ACKOUT;
                        if (byte_idx >= CW'(3)) begin
                           wr_en   <= 1'b1;
                           wr_idx  <= IW'(byte_idx - CW'(3));
                           wr_data <= shreg;
                        end
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               ST_ACKOUT: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (is_rd) begin
                        st     <= ST_SEND;
                        shreg  <= 8'(NR);
                        sda_oe <= ~(8'(NR) >> 7);
                     end else begin
                        sda_oe   <= 1'b0;
                        st       <= ST_RECV;
                        byte_idx <= byte_idx + CW'(1);
                     end
                  end
               end
               ST_SEND: begin
                  if (scl_fall) begin
                     if (bitcnt == 4'd7) begin
                        sda_oe <= 1'b0;
                        st     <= ST_ACKIN;
                     end else begin
                        shreg  <= {shreg[6:0], 1'b0};
                        sda_oe <= ~shreg[6];
                        bitcnt <= bitcnt + 4'd1;
                     end
                  end
               end
               ST_ACKIN: begin
                  if (scl_rise) begin
                     acked <= ~sda_s;
                  end else if (scl_fall) begin
                     if (acked && byte_idx < CW'(NR)) begin
                        byte_idx <= byte_idx + CW'(1);
                        shreg    <= rd_byte_i;
                        sda_oe   <= ~rd_byte_i[7];
                        bitcnt   <= '0;
                        st       <= ST_SEND;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assert_oe_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !sda_oe);
   assert_oe_rise_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_s);
   assert_wr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_idx) < NR));
   assert_wr_with_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (st == ST_ACKOUT && sda_oe));

endmodule

// File: rtl/clkcfg_regbank.sv
module clkcfg_regbank
   import clkcfg_pkg::*;
#(
   parameter int         NR     = NREG,
   parameter logic [3:0] REV_ID = 4'h2,
   localparam int        IW     = $clog2(NR)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [IW-1:0]   wr_idx,
   input  logic [7:0]      wr_data,
   input  logic [1:0]      fsel_pins,
   input  logic            sel_pin,
   output logic [NR*8-1:0] view_o
);
   generate
      if (NR < 7) begin : g_bad_nr
         $error("clkcfg_regbank: at least seven bytes are required");
      end
   endgenerate

   logic       cap_done;
   logic [1:0] fs_lat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_done <= 1'b0;
         fs_lat   <= 2'b00;
      end else if (!cap_done) begin
         cap_done <= 1'b1;
         fs_lat   <= fsel_pins;
      end
   end

   logic [7:0] ro [NR];
   always_comb begin
      for (int k = 0; k < NR; k++) ro[k] = 8'h00;
      ro[0][2:1] = fs_lat;
      ro[1][7]   = sel_pin;
      ro[6]      = {REV_ID, 4'b0001};
   end

   for (genvar i = 0; i < NR; i++) begin : g_byte
      localparam logic [7:0] WM = reg_wmask(i);
      localparam logic [7:0] DF = reg_default(i);
      logic [7:0] q;
      if (WM != 8'h00) begin : g_rw
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= DF & WM;
            else if (wr_en && wr_idx == IW'(i)) q <= wr_data & WM;
         end
      end else begin : g_ro
         assign q = 8'h00;
      end
      assign view_o[i*8 +: 8] = q | ro[i];
   end

   assert_fs_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cap_done |=> $stable(fs_lat));

endmodule

// File: rtl/clkcfg_smb_slave.sv
module clkcfg_smb_slave
   import clkcfg_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter logic [6:0] DEV_ADDR    = 7'h69,
   parameter logic [3:0] REV_ID      = 4'h2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_i,
   input  logic          sda_i,
   output logic          sda_oe,
   input  logic [1:0]    fsel_pins,
   input  logic          sel_pin,
   output logic [NREG*8-1:0] cfg_o
);
   localparam int IW = $clog2(NREG);

   logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic          wr_en;
   logic [IW-1:0] wr_idx, rd_sel;
   logic [7:0]    wr_data, rd_byte;

   smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   smb_proto #(.DEV_ADDR(DEV_ADDR), .NR(NREG)) u_proto (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det),
      .rd_byte_i(rd_byte), .rd_sel(rd_sel), .sda_oe(sda_oe),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
   );

   clkcfg_regbank #(.NR(NREG), .REV_ID(REV_ID)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .fsel_pins(fsel_pins), .sel_pin(sel_pin),
      .view_o(cfg_o)
   );

   always_comb begin
      rd_byte = 8'h00;
      for (int k = 0; k < NREG; k++)
         if (rd_sel == IW'(k)) rd_byte = cfg_o[k*8 +: 8];
   end

endmodule

// File: tb/clkcfg_smb_slave_tb.sv
module clkcfg_smb_slave_tb;
   localparam int H = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl = 1'b1;
   logic        sda_m = 1'b1;
   logic [1:0]  fsel = 2'b10;
   logic        sel = 1'b0;
   logic        sda_oe;
   logic [55:0] cfg;
   wire         sda_bus = sda_m & ~sda_oe;

   int nchk = 0, nfail = 0;
   bit done = 0;
   logic [7:0] expw [7];
   logic [7:0] rbuf [8];
   logic [7:0] wdat [8];
   logic       wack [11];
   logic       rack;
   logic [1:0] fs_pu;

   always #2 clk = ~clk;

   clkcfg_smb_slave u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
      .sda_oe(sda_oe), .fsel_pins(fsel), .sel_pin(sel), .cfg_o(cfg)
   );

   function automatic logic [7:0] wm(input int i);
      case (i)
         0: return 8'hA8; 1: return 8'h47; 2: return 8'h7F;
         3: return 8'hFF; 4: return 8'h3F; 5: return 8'h0F;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] view(input int i);
      logic [7:0] v;
      v = expw[i] & wm(i);
      if (i == 0) v = v | {5'b0, fs_pu, 1'b0};
      if (i == 1) v = v | {sel, 7'b0};
      if (i == 6) v = 8'h21;
      return v;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wc(input int n); repeat (n) @(negedge clk); endtask

   task automatic put_bit(input logic b);
      sda_m = b; wc(H); scl = 1'b1; wc(H); scl = 1'b0;
   endtask

   task automatic get_bit(output logic b);
      sda_m = 1'b1; wc(H); scl = 1'b1; wc(H/2); b = sda_bus; wc(H/2); scl = 1'b0;
   endtask

   task automatic smb_start;
      sda_m = 1'b1; wc(H); scl = 1'b1; wc(H); sda_m = 1'b0; wc(H); scl = 1'b0;
   endtask

   task automatic smb_stop;
      sda_m = 1'b0; wc(H); scl = 1'b1; wc(H); sda_m = 1'b1; wc(H);
   endtask

   task automatic put_byte(input logic [7:0] b, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) put_bit(b[i]);
      get_bit(s);
      ack = ~s;
   endtask

   task automatic get_byte(output logic [7:0] b, input logic mack);
      logic s;
      for (int i = 7; i >= 0; i--) begin get_bit(s); b[i] = s; end
      put_bit(~mack);
   endtask

   // write: address, cmd, count, then n data bytes from wdat
   task automatic smb_write(input logic [7:0] cmd, input logic [7:0] cnt, input int n);
      smb_start;
      put_byte(8'hD2, wack[0]);
      put_byte(cmd, wack[1]);
      put_byte(cnt, wack[2]);
      for (int i = 0; i < n; i++) put_byte(wdat[i], wack[3+i]);
      smb_stop;
   endtask

   task automatic smb_read;
      smb_start;
      put_byte(8'hD3, rack);
      for (int i = 0; i < 8; i++) get_byte(rbuf[i], i != 7);
      smb_stop;
   endtask

   task automatic read_and_check(input string req);
      smb_read;
      chk(rack == 1'b1, "R2 read address ack", rack, 1);
      chk(rbuf[0] == 8'h07, "R5 count byte", rbuf[0], 8'h07);
      for (int i = 0; i < 7; i++) begin
         chk(rbuf[i+1] == view(i), req, rbuf[i+1], view(i));
         chk(cfg[i*8 +: 8] == view(i), {req, " cfg_o"}, cfg[i*8 +: 8], view(i));
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

   initial begin
      logic [7:0] pats [5];
      logic b;
      pats[0] = 8'hFF; pats[1] = 8'h00; pats[2] = 8'hA5; pats[3] = 8'h5A; pats[4] = 8'h3C;
      for (int i = 0; i < 7; i++) expw[i] = 8'h00;
      expw[0] = 8'h08; expw[1] = 8'h47; expw[2] = 8'h7F; expw[3] = 8'hC7; expw[4] = 8'h3F;
      fs_pu = 2'b10;
      wc(5); rst_n = 1'b1; wc(5);
      fsel = 2'b01;            // later pin changes must not show (R7)
      chk(sda_oe == 1'b0, "R1 reset sda released", sda_oe, 0);
      for (int i = 0; i < 7; i++)
         chk(cfg[i*8 +: 8] == view(i), "R1 reset value", cfg[i*8 +: 8], view(i));
      read_and_check("R1 R5 reset readback");

      // R4 R6 R7 R8: full writes with a pattern sweep
      for (int p = 0; p < 5; p++) begin
         for (int i = 0; i < 7; i++) begin
            wdat[i] = pats[p] ^ 8'(i * 8'h11);
            expw[i] = wdat[i];
         end
         sel = p[0];
         smb_write(8'h00, 8'h07, 7);
         for (int i = 0; i < 10; i++) chk(wack[i] == 1'b1, "R2 R3 write ack", wack[i], 1);
         read_and_check("R4 R6 R7 R8 pattern");
      end

      // R3: cmd/count values have no effect; R4 partial write keeps rest
      wdat[0] = 8'h88; wdat[1] = 8'h12;
      smb_write(8'h05, 8'h01, 2);
      expw[0] = 8'h88; expw[1] = 8'h12;
      chk(wack[1] == 1'b1 && wack[2] == 1'b1, "R3 cmd/count ack", {wack[1], wack[2]}, 3);
      read_and_check("R3 R4 partial write");

      // R2: wrong address not acknowledged, nothing changes
      smb_start;
      put_byte(8'hD4, b);
      chk(b == 1'b0, "R2 foreign address nack", b, 0);
      put_byte(8'h00, b); put_byte(8'h00, b); put_byte(8'h00, b);
      smb_stop;
      read_and_check("R2 foreign address ignored");

      // R11: eighth data byte refused
      for (int i = 0; i < 8; i++) wdat[i] = 8'h40 + 8'(i);
      smb_write(8'h00, 8'h08, 8);
      chk(wack[10] == 1'b0, "R11 extra byte nack", wack[10], 0);
      for (int i = 0; i < 7; i++) expw[i] = wdat[i];
      read_and_check("R11 extra byte not stored");

      // R10: STOP inside a byte
      smb_start;
      put_byte(8'hD2, b); put_byte(8'h00, b); put_byte(8'h00, b);
      put_byte(8'hFF, b);
      put_bit(1'b0); put_bit(1'b0); put_bit(1'b0); put_bit(1'b0);
      smb_stop;
      expw[0] = 8'hFF;
      read_and_check("R10 stop mid-byte");

      // R10: START inside a byte
      smb_start;
      put_byte(8'hD2, b); put_byte(8'h00, b); put_byte(8'h00, b);
      put_byte(8'h00, b);
      put_bit(1'b1); put_bit(1'b1); put_bit(1'b1);
      smb_start;
      smb_stop;
      expw[0] = 8'h00;
      read_and_check("R10 start mid-byte");

      // R9: master NACK on count byte, slave must stay released
      smb_start;
      put_byte(8'hD3, b);
      get_byte(rbuf[0], 1'b0);
      chk(rbuf[0] == 8'h07, "R9 count before nack", rbuf[0], 7);
      get_bit(b);
      chk(b == 1'b1, "R9 sda released after nack", b, 1);
      chk(sda_oe == 1'b0, "R9 sda_oe low after nack", sda_oe, 0);
      smb_stop;

      // R7: latched select pins stay, live pin follows
      sel = 1'b1; fsel = 2'b11;
      wc(10);
      chk(cfg[2:1] == fs_pu, "R7 latched fsel", cfg[2:1], fs_pu);
      chk(cfg[15] == 1'b1, "R7 live sel", cfg[15], 1);
      read_and_check("R7 status readback");

      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule